// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen transfers without help from the host. Each list slot holds three things: a word to send, a word that was received, and a chip-select pattern. The host fills the send and chip-select slots through a small register port, names the first and last slot, and sets a run bit. The controller then visits the slots in order and wraps from 15 back to 0. For each slot it drives that slot's chip-select pattern, shifts one word out on MOSI, and takes one word in from MISO. At the end it sets a completion flag that can raise an interrupt.

The three slot arrays sit behind one data register. A six-bit pointer register chooses the array and the slot, and the pointer steps forward after every data access. A mode register sets the serial clock divider, the word length and the edge on which data is launched. A control register holds the run bit and a gap between slots. A wrap register holds the first and last slots. An interrupt register holds two flags that are cleared by writing 1, and an enable for each flag.

Top module: `spi_queue_master`

Register port (select code: register):
- 0: MODE.
  - [7:0] is the divider.
  - [11:8] is the bits per word, where 0 means 16.
  - [12] set means launch on the falling edge.
- 1: CTRL.
  - [15] is the run bit.
  - [7:0] is the gap.
- 2: WRAP.
  - [3:0] is the first slot.
  - [11:8] is the last slot.
- 3: IRQ.
  - [0] is the done flag.
  - [1] is the collision flag.
  - [8] enables the done flag onto the interrupt.
  - [9] enables the collision flag onto the interrupt.
- 4: PTR.
- 5: DATA.

## Requirements
- R1: After reset, these outputs and registers hold the following values:
  - `cs_n` is 4'hF.
  - `sclk` is 0.
  - `mosi` is 0.
  - `irq` is 0.
  - CTRL reads 0.
  - IRQ reads 0.
- R2: The pointer picks the array and slot reached through DATA:
  - Pointer values 0x00–0x0F reach the transmit array.
  - Pointer values 0x10–0x1F reach the receive array, which DATA can read.
  - Pointer values 0x20–0x2F reach the chip-select array, which takes bits [3:0].
  - Every DATA read or write adds 1 to the pointer.
- R3: Each slot shifts exactly MODE[11:8] bits, or 16 bits when the field is 0. The word is sent MSB first, and the received word is stored right-aligned with zeros above it.
- R4: `sclk` idles low. With MODE[12]=1, MOSI changes only while `sclk` is low and MISO is sampled on the rising edge. With MODE[12]=0, MOSI changes only on the rising edge and MISO is sampled on the falling edge.
- R5: Each `sclk` half-period lasts MODE[7:0] clock cycles. A write that sets CTRL[15] while MODE[7:0] is 0 is ignored, so the run bit stays 0 and no clock appears.
- R6: The queue visits every slot from WRAP[3:0] to WRAP[11:8], both included, and wraps from 15 to 0. Each received word goes to the slot of the same index. Receive slots outside that range keep their contents.
- R7: While a slot is shifting, `cs_n` equals that slot's chip-select entry. At all other times `cs_n` is 4'hF.
- R8: When the last slot finishes, IRQ[0] sets and CTRL[15] clears. `irq` = (IRQ[0]&IRQ[8]) | (IRQ[1]&IRQ[9]).
- R9: A DATA write while CTRL[15] is 1 sets IRQ[1] and does not change any array.
- R10: Writing 1 to IRQ[0] or IRQ[1] clears that flag. Writing 0 to a flag leaves it unchanged.
- R11: Between two consecutive slots, `cs_n` stays 4'hF for exactly CTRL[7:0]+2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select code |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (advances the pointer on DATA) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_sel` |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The hardest case to reach is a queue whose range crosses slot 15. To fill it, the bench must move the pointer by hand across the gap where a step from 0x2F lands in an unused bank. It must then check that the untouched receive slot 2 still holds the word from the earlier run.

A second hard case is a DATA write made while a run is in progress. The bench starts a one-slot queue and writes at once, so the write falls inside the short shifting window.

MISO is looped back to MOSI. The bench checks both launch modes by noting the level of `sclk` at each MOSI change and by capturing bits on the sampling edge.

// File: rtl/spi_queue_pkg.sv
// Package: shared constants and types for the queued SPI master.
// Assumes: register select codes and pointer bank codes are fixed by this package.
package spi_queue_pkg;
    localparam int REG_W = 16;

    typedef enum logic [2:0] {
        SEL_MODE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_WRAP = 3'd2,
        SEL_IRQ  = 3'd3,
        SEL_PTR  = 3'd4,
        SEL_DATA = 3'd5
    } reg_sel_e;

    localparam logic [1:0] BANK_TX  = 2'd0;
    localparam logic [1:0] BANK_RX  = 2'd1;
    localparam logic [1:0] BANK_CMD = 2'd2;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_XFER  = 2'd2,
        SQ_GAP   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/spi_queue_ram.sv
// Module: small slot array with one synchronous write port and one combinational read port.
// Assumes: contents are not reset; the user writes a slot before reading it.
module spi_queue_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store one slot on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed slot.
    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_queue_shifter.sv
// Module: shifts one word of nbits on SCLK, with the divider and the launch edge selectable.
// Assumes: start is a single-cycle pulse given only while idle, and baud is nonzero.
// SCLK idles low, and every word ends after an even number of edges.
module spi_queue_shifter #(
    parameter int DATA_W = 16,
    parameter int BAUD_W = 8,
    localparam int NB_W = $clog2(DATA_W) + 1,
    localparam int CNT_W = NB_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [NB_W-1:0]   nbits,
    input  logic [BAUD_W-1:0] baud,
    input  logic              launch_fall,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] out_sr, rx_sr, aligned;
    logic [BAUD_W-1:0] div_cnt;
    logic [CNT_W-1:0]  edge_cnt;
    logic              sclk_q, out_bit, busy_q, done_q, last_edge;

    // Left-align the word so that the MSB of the active field leaves first.
    assign aligned   = tx_word << (DATA_W - int'(nbits));
    assign last_edge = (edge_cnt == ({nbits, 1'b0} - 1'b1));

    // Divider, edge counter, and the launch and sample shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr   <= '0;
            rx_sr    <= '0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
            out_bit  <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q   <= 1'b1;
                div_cnt  <= baud - 1'b1;
                edge_cnt <= '0;
                sclk_q   <= 1'b0;
                rx_sr    <= '0;
                if (launch_fall) begin
                    out_bit <= aligned[DATA_W-1];
                    out_sr  <= aligned << 1;
                end else begin
                    out_sr  <= aligned;
                end
            end else if (busy_q) begin
                if (div_cnt == '0) begin
                    div_cnt  <= baud - 1'b1;
                    sclk_q   <= ~sclk_q;
                    edge_cnt <= edge_cnt + 1'b1;
                    if (sclk_q != launch_fall) begin
                        rx_sr <= {rx_sr[DATA_W-2:0], miso};
                    end else begin
                        out_bit <= out_sr[DATA_W-1];
                        out_sr  <= out_sr << 1;
                    end
                    if (last_edge) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    div_cnt <= div_cnt - 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = out_bit;
    assign done    = done_q;
    assign rx_word = rx_sr;

    // R4: the clock is low whenever no word is in flight.
    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q) else $error("sclk high while idle");
    // R5: no clock edge before the divider reaches zero.
    assert_half_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && div_cnt != '0) |=> $stable(sclk_q)) else $error("early sclk edge");
    // R3: the end-of-word pulse lasts one cycle.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q) else $error("done longer than one cycle");
endmodule

// File: rtl/spi_queue_seq.sv
// Module: walks the slots from the first index to the last, drives each chip-select pattern,
// starts the shifter, and spaces the slots by a programmable gap.
// Assumes: run stays high until finish, and the index wraps modulo the depth.
module spi_queue_seq
    import spi_queue_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int CS_W    = 4,
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [IDX_W-1:0]   start_idx,
    input  logic [IDX_W-1:0]   end_idx,
    input  logic [DELAY_W-1:0] delay,
    input  logic [CS_W-1:0]    cmd_cs,
    input  logic               shift_done,
    output logic [IDX_W-1:0]   cur_idx,
    output logic               shift_start,
    output logic               rx_we,
    output logic [CS_W-1:0]    cs_n,
    output logic               finish
);
    seq_state_e         state;
    logic [IDX_W-1:0]   idx;
    logic [DELAY_W-1:0] gap_cnt;
    logic [CS_W-1:0]    cs_q;
    logic               start_q;

    // Step the slot state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            gap_cnt <= '0;
            cs_q    <= '1;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                SQ_IDLE: if (run) begin
                    idx   <= start_idx;
                    state <= SQ_SETUP;
                end
                SQ_SETUP: begin
                    cs_q    <= cmd_cs;
                    start_q <= 1'b1;
                    state   <= SQ_XFER;
                end
                SQ_XFER: if (shift_done) begin
                    cs_q    <= '1;
                    gap_cnt <= delay;
                    state   <= SQ_GAP;
                end
                default: begin
                    if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end else if (idx == end_idx) begin
                        state <= SQ_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= SQ_SETUP;
                    end
                end
            endcase
        end
    end

    assign finish      = (state == SQ_GAP) && (gap_cnt == '0) && (idx == end_idx);
    assign rx_we       = (state == SQ_XFER) && shift_done;
    assign cur_idx     = idx;
    assign shift_start = start_q;
    assign cs_n        = cs_q;

    // R7: chip selects are released outside the shifting state.
    assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_XFER) |-> (cs_q == '1)) else $error("cs active outside transfer");
    // R6: a run begins at the programmed first slot.
    assert_first_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && run) |=> (state == SQ_SETUP && idx == $past(start_idx)))
        else $error("queue did not start at first slot");
endmodule

// File: rtl/spi_queue_master.sv
// Module: top of the queued SPI master.
// It holds the host registers, the three slot arrays, the sequencer and the shifter.
// Assumes: one register access per cycle. reg_rdata is combinational from reg_sel.
// The transmit and chip-select arrays are write-only from the host.
module spi_queue_master
    import spi_queue_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 16,
    parameter int CS_W    = 4,
    parameter int BAUD_W  = 8,
    parameter int DELAY_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 2,
    localparam int NB_W  = $clog2(DATA_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [CS_W-1:0]  cs_n
);
    logic [BAUD_W-1:0]  baud_q;
    logic [3:0]         bits_q;
    logic               lfall_q, run_q;
    logic [DELAY_W-1:0] delay_q;
    logic [IDX_W-1:0]   first_q, last_q;
    logic [1:0]         irq_en_q, flags_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [1:0]         bank;
    logic [IDX_W-1:0]   pidx, cur_idx;
    logic               data_wr, data_acc, host_wr_ok;
    logic [DATA_W-1:0]  tx_rd, rx_rd, rx_word;
    logic [CS_W-1:0]    cmd_rd;
    logic [NB_W-1:0]    nbits;
    logic               shift_start, shift_done, rx_we, seq_finish;

    assign bank       = ptr_q[PTR_W-1 -: 2];
    assign pidx       = ptr_q[IDX_W-1:0];
    assign data_wr    = reg_wr && (reg_sel == SEL_DATA);
    assign data_acc   = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
    assign host_wr_ok = data_wr && !run_q;
    assign nbits      = (bits_q == 4'd0) ? NB_W'(DATA_W) : NB_W'(bits_q);

    // Host register writes, pointer stepping, run control and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q   <= '0;
            bits_q   <= '0;
            lfall_q  <= 1'b0;
            run_q    <= 1'b0;
            delay_q  <= '0;
            first_q  <= '0;
            last_q   <= '0;
            irq_en_q <= '0;
            flags_q  <= '0;
            ptr_q    <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_MODE: begin
                        baud_q  <= reg_wdata[BAUD_W-1:0];
                        bits_q  <= reg_wdata[11:8];
                        lfall_q <= reg_wdata[12];
                    end
                    SEL_CTRL: begin
                        delay_q <= reg_wdata[DELAY_W-1:0];
                        if (!run_q) run_q <= reg_wdata[15] && (baud_q != '0);
                    end
                    SEL_WRAP: begin
                        first_q <= reg_wdata[IDX_W-1:0];
                        last_q  <= reg_wdata[8 +: IDX_W];
                    end
                    SEL_IRQ: begin
                        irq_en_q <= reg_wdata[9:8];
                        flags_q  <= flags_q & ~reg_wdata[1:0];
                    end
                    SEL_PTR: ptr_q <= reg_wdata[PTR_W-1:0];
                    default: ;
                endcase
            end
            if (data_acc) ptr_q <= ptr_q + 1'b1;
            if (data_wr && run_q) flags_q[1] <= 1'b1;
            if (seq_finish) begin
                flags_q[0] <= 1'b1;
                run_q      <= 1'b0;
            end
        end
    end

    // Read mux for the host port.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_MODE: begin
                reg_rdata[BAUD_W-1:0] = baud_q;
                reg_rdata[11:8]       = bits_q;
                reg_rdata[12]         = lfall_q;
            end
            SEL_CTRL: begin
                reg_rdata[15]          = run_q;
                reg_rdata[DELAY_W-1:0] = delay_q;
            end
            SEL_WRAP: begin
                reg_rdata[IDX_W-1:0]  = first_q;
                reg_rdata[8 +: IDX_W] = last_q;
            end
            SEL_IRQ: begin
                reg_rdata[9:8] = irq_en_q;
                reg_rdata[1:0] = flags_q;
            end
            SEL_PTR:  reg_rdata[PTR_W-1:0] = ptr_q;
            SEL_DATA: if (bank == BANK_RX) reg_rdata[DATA_W-1:0] = rx_rd;
            default: ;
        endcase
    end

    assign irq = |(flags_q & irq_en_q);

    spi_queue_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_ram (
        .clk(clk), .we(host_wr_ok && bank == BANK_TX), .waddr(pidx),
        .wdata(reg_wdata[DATA_W-1:0]), .raddr(cur_idx), .rdata(tx_rd));

    spi_queue_ram #(.WIDTH(CS_W), .DEPTH(DEPTH)) u_cmd_ram (
        .clk(clk), .we(host_wr_ok && bank == BANK_CMD), .waddr(pidx),
        .wdata(reg_wdata[CS_W-1:0]), .raddr(cur_idx), .rdata(cmd_rd));

    spi_queue_ram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_ram (
        .clk(clk), .we(rx_we), .waddr(cur_idx),
        .wdata(rx_word), .raddr(pidx), .rdata(rx_rd));

    spi_queue_seq #(.IDX_W(IDX_W), .CS_W(CS_W), .DELAY_W(DELAY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run_q), .start_idx(first_q), .end_idx(last_q),
        .delay(delay_q), .cmd_cs(cmd_rd), .shift_done(shift_done), .cur_idx(cur_idx),
        .shift_start(shift_start), .rx_we(rx_we), .cs_n(cs_n), .finish(seq_finish));

    spi_queue_shifter #(.DATA_W(DATA_W), .BAUD_W(BAUD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(shift_start), .tx_word(tx_rd), .nbits(nbits),
        .baud(baud_q), .launch_fall(lfall_q), .miso(miso), .sclk(sclk), .mosi(mosi),
        .done(shift_done), .rx_word(rx_word));

    // R5: a run can only begin with a nonzero divider.
    assert_run_needs_baud_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> ($past(baud_q) != '0)) else $error("run with zero divider");
    // R8: finishing the last slot sets done and drops run.
    assert_finish_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_finish |=> (!run_q && flags_q[0])) else $error("finish not reported");
    // R9: a data write during a run raises the collision flag.
    assert_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && run_q) |=> flags_q[1]) else $error("collision missed");
    // R6: received words are stored only during a run.
    assert_rx_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> run_q) else $error("receive write outside run");
endmodule

// File: tb/spi_queue_master_bench.sv
// Directed bench for spi_queue_master. MISO is looped back to MOSI.
// A monitor records each word and its chip selects, the gap and the SCLK high time.
module spi_queue_master_bench;
    import spi_queue_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  cs_n;

    int n_checks = 0, n_fail = 0;

    assign miso = mosi;
    always #(CLK_PERIOD/2) clk = ~clk;

    spi_queue_master u_spi_queue_master (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n));

    // Monitor state
    bit          lf_mode = 1'b1;
    int          mon_n = 0, cap_bits = 0, gap_cnt = 0, last_gap = -1, hp = 0, last_high = -1, edge_err = 0;
    logic [15:0] cap = '0;
    logic [3:0]  cap_cs = 4'hF, cs_prev = 4'hF;
    logic        sclk_prev = 1'b0, mosi_prev = 1'b0;
    logic [15:0] mon_word [32];
    int          mon_bits [32];
    logic [3:0]  mon_cs   [32];

    always @(posedge sclk) if (lf_mode) begin
        cap = {cap[14:0], mosi}; cap_bits++; cap_cs = cs_n;
    end
    always @(negedge sclk) if (!lf_mode) begin
        cap = {cap[14:0], mosi}; cap_bits++; cap_cs = cs_n;
    end

    always @(negedge clk) begin
        if (cs_prev != 4'hF && cs_n == 4'hF && mon_n < 32) begin
            mon_word[mon_n] = cap; mon_bits[mon_n] = cap_bits; mon_cs[mon_n] = cap_cs;
            mon_n++; cap = '0; cap_bits = 0;
        end
        if (cs_n == 4'hF) gap_cnt++;
        else begin
            if (cs_prev == 4'hF && mon_n > 0) last_gap = gap_cnt;
            gap_cnt = 0;
        end
        if (sclk && !sclk_prev) hp = 1;
        else if (sclk) hp++;
        if (!sclk && sclk_prev) last_high = hp;
        if (cs_n != 4'hF && mosi !== mosi_prev && sclk !== (lf_mode ? 1'b0 : 1'b1)) edge_err++;
        cs_prev = cs_n; sclk_prev = sclk; mosi_prev = mosi;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic mon_clear();
        @(negedge clk);
        mon_n = 0; cap = '0; cap_bits = 0; last_gap = -1; last_high = -1; edge_err = 0;
    endtask

    task automatic wait_done(input string req);
        logic [15:0] v;
        int k;
        for (k = 0; k < 20000; k++) begin
            reg_read(SEL_CTRL, v);
            if (!v[15]) break;
        end
        check(req, int'(k < 20000), 1);
    endtask

    function automatic logic [15:0] pat(input int i, input logic [15:0] seed);
        return seed ^ 16'(i * 16'h1357);
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        check("R1 cs_n", cs_n, 4'hF);
        check("R1 sclk", sclk, 0);
        check("R1 mosi", mosi, 0);
        check("R1 irq", irq, 0);
        reg_read(SEL_CTRL, v); check("R1 CTRL", v, 0);
        reg_read(SEL_IRQ, v);  check("R1 IRQ", v, 0);
    endtask

    task automatic t_pointer();
        logic [15:0] v;
        reg_write(SEL_PTR, 16'h0005);
        for (int i = 0; i < 3; i++) reg_write(SEL_DATA, 16'h1234);
        reg_read(SEL_PTR, v); check("R2 ptr after writes", v, 16'h0008);
        reg_write(SEL_PTR, 16'h0013);
        reg_read(SEL_DATA, v);
        reg_read(SEL_PTR, v); check("R2 ptr after read", v, 16'h0014);
    endtask

    // Sixteen 12-bit words, falling-edge launch, divider 2, gap 3.
    task automatic t_full_queue();
        logic [15:0] v;
        logic [3:0] csv [4] = '{4'hE, 4'hD, 4'hB, 4'h7};
        lf_mode = 1'b1;
        reg_write(SEL_MODE, 16'h1C02);
        reg_write(SEL_IRQ, 16'h0303);
        reg_write(SEL_PTR, 16'h0020);
        for (int i = 0; i < 16; i++) reg_write(SEL_DATA, {12'h0, csv[i/4]});
        reg_write(SEL_PTR, 16'h0000);
        for (int i = 0; i < 16; i++) reg_write(SEL_DATA, pat(i, 16'hA5C3));
        reg_write(SEL_WRAP, 16'h0F00);
        mon_clear();
        reg_write(SEL_CTRL, 16'h8003);
        wait_done("R8 run ends");
        check("R6 word count", mon_n, 16);
        for (int i = 0; i < 16; i++) begin
            check("R3 mosi bits", mon_word[i] & 16'h0FFF, pat(i, 16'hA5C3) & 16'h0FFF);
            check("R3 bit count", mon_bits[i], 12);
            check("R7 cs pattern", mon_cs[i], csv[i/4]);
        end
        reg_write(SEL_PTR, 16'h0010);
        for (int i = 0; i < 16; i++) begin
            reg_read(SEL_DATA, v);
            check("R6 rx slot", v, pat(i, 16'hA5C3) & 16'h0FFF);
        end
        reg_read(SEL_IRQ, v); check("R8 IRQ reg", v, 16'h0301);
        check("R8 irq pin", irq, 1);
        check("R7 cs idle", cs_n, 4'hF);
        check("R11 gap", last_gap, 5);
        check("R5 half period", last_high, 2);
        check("R4 launch falling", edge_err, 0);
    endtask

    // W1C, then 8-bit words with rising-edge launch, wrapping queue 14..1.
    task automatic t_wrap_queue();
        logic [15:0] v;
        int order [4] = '{14, 15, 0, 1};
        logic [3:0] csv [4] = '{4'h7, 4'hB, 4'hD, 4'hE};
        reg_write(SEL_IRQ, 16'h0300);
        reg_read(SEL_IRQ, v); check("R10 zero keeps", v, 16'h0301);
        reg_write(SEL_IRQ, 16'h0301);
        reg_read(SEL_IRQ, v); check("R10 one clears", v, 16'h0300);
        check("R8 irq low", irq, 0);
        lf_mode = 1'b0;
        reg_write(SEL_MODE, 16'h0803);
        reg_write(SEL_PTR, 16'h002E);
        reg_write(SEL_DATA, 16'h0007); reg_write(SEL_DATA, 16'h000B);
        reg_write(SEL_PTR, 16'h0020);
        reg_write(SEL_DATA, 16'h000D); reg_write(SEL_DATA, 16'h000E);
        reg_write(SEL_PTR, 16'h000E);
        reg_write(SEL_DATA, pat(14, 16'h3C96)); reg_write(SEL_DATA, pat(15, 16'h3C96));
        reg_write(SEL_PTR, 16'h0000);
        reg_write(SEL_DATA, pat(0, 16'h3C96)); reg_write(SEL_DATA, pat(1, 16'h3C96));
        reg_write(SEL_WRAP, 16'h010E);
        mon_clear();
        reg_write(SEL_CTRL, 16'h8000);
        wait_done("R8 wrap run ends");
        check("R6 wrap count", mon_n, 4);
        for (int j = 0; j < 4; j++) begin
            check("R3 8-bit word", mon_word[j] & 16'h00FF, pat(order[j], 16'h3C96) & 16'h00FF);
            check("R3 8 bits", mon_bits[j], 8);
            check("R7 wrap cs", mon_cs[j], csv[j]);
        end
        reg_write(SEL_PTR, 16'h001E);
        reg_read(SEL_DATA, v); check("R6 rx 14", v, pat(14, 16'h3C96) & 16'h00FF);
        reg_read(SEL_DATA, v); check("R6 rx 15", v, pat(15, 16'h3C96) & 16'h00FF);
        reg_write(SEL_PTR, 16'h0010);
        reg_read(SEL_DATA, v); check("R6 rx 0", v, pat(0, 16'h3C96) & 16'h00FF);
        reg_read(SEL_DATA, v); check("R6 rx 1", v, pat(1, 16'h3C96) & 16'h00FF);
        reg_read(SEL_DATA, v); check("R6 rx 2 kept", v, pat(2, 16'hA5C3) & 16'h0FFF);
        check("R11 zero gap", last_gap, 2);
        check("R5 divider 3", last_high, 3);
        check("R4 launch rising", edge_err, 0);
    endtask

    task automatic t_zero_baud();
        logic [15:0] v;
        reg_write(SEL_MODE, 16'h0C00);
        reg_write(SEL_CTRL, 16'h8000);
        reg_read(SEL_CTRL, v); check("R5 run ignored", v, 16'h0000);
        repeat (40) @(negedge clk);
        check("R5 no sclk", sclk, 0);
        check("R7 cs stays high", cs_n, 4'hF);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        lf_mode = 1'b1;
        reg_write(SEL_MODE, 16'h1C02);
        reg_write(SEL_PTR, 16'h0000);
        reg_write(SEL_DATA, 16'h0ABC);
        reg_write(SEL_PTR, 16'h0020);
        reg_write(SEL_DATA, 16'h000E);
        reg_write(SEL_WRAP, 16'h0000);
        reg_write(SEL_CTRL, 16'h8000);
        reg_write(SEL_PTR, 16'h0000);
        reg_write(SEL_DATA, 16'h0FFF);
        wait_done("R9 run ends");
        reg_read(SEL_IRQ, v); check("R9 collision flag", v, 16'h0303);
        check("R8 irq from collision", irq, 1);
        reg_write(SEL_PTR, 16'h0010);
        reg_read(SEL_DATA, v); check("R9 tx unchanged", v, 16'h0ABC);
        reg_write(SEL_IRQ, 16'h0303);
        reg_read(SEL_IRQ, v); check("R10 both cleared", v, 16'h0300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_full_queue();
        t_wrap_queue();
        t_zero_baud();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule